// File: doc/BRIEF.md
# Parallel port floppy pin-sharing controller

This block decides who owns the pins of a parallel port. In normal operation the parallel-port engine drives the pins and answers host register reads. When software puts the block into one of two floppy modes, the floppy controller takes over the parallel pins. From then on the port cannot act as a printer port until normal mode is restored.

While a floppy mode is active, host reads of the parallel registers return constant values that mean "no cable attached". The one exception is the data register, which echoes whatever the host last wrote to it. The block also watches the floppy drive-select signals. When the selected drive is one that the current mode routes to the parallel pins, it floats the floppy controller's dedicated pins.

Mode 1 routes only drive 1 to the parallel pins. Mode 2 routes both drive 0 and drive 1. The mapping from floppy signals to individual parallel pins is done outside this block. The block receives those signals already arranged in parallel-pin order.

Top module: `ppfd_pinshare`

## Requirements
- R1: After reset the stored mode is 2'b00 (normal) and the data echo register holds 8'h00, so the first floppy-mode data read with no prior data write returns 8'h00.
- R2: A pulse on `cfg_wr` stores `cfg_wdata` as the 2-bit mode. `cfg_mode` shows the stored raw value from the next cycle on, and the new mode takes effect in that same cycle. Encoding: 00 normal, 01 floppy mode 1, 10 floppy mode 2, 11 reserved and behaving as normal.
- R3: In normal mode (00 or 11), `pp_pin_out` equals `eng_pin_out` and `pp_pin_oe` equals `eng_pin_oe` masked by `eng_enable`. In this mode, reads with `reg_sel` 0/1/2 return `eng_data_rd`/`eng_status_rd`/`eng_ctrl_rd`, and `eng_reg_wr` follows `reg_wr`.
- R4: In either floppy mode, `pp_pin_out` equals `fdc_pin_out` and `pp_pin_oe` equals `fdc_pin_oe`, whatever the value of `eng_enable`.
- R5: In either floppy mode, `eng_reg_wr` stays 0 even when the host writes.
- R6: A write with `reg_sel`=0 is captured in every mode. In a floppy mode, a read with `reg_sel`=0 returns the most recently captured byte, starting from the cycle after the write.
- R7: In a floppy mode, a read with `reg_sel`=1 (status) returns 8'h48. Bit layout: bits 2:0 = 0, bit 3 error_n = 1, bit 4 select = 0, bit 5 paper-end = 0, bit 6 ack_n = 1, bit 7 busy_n = 0.
- R8: In a floppy mode, a read with `reg_sel`=2 (control) returns 8'h04. Bit layout: bit 0 strobe = 0, bit 1 auto-feed = 0, bit 2 init_n = 1, bit 3 select-in = 0, bits 7:4 = 0.
- R9: A read with `reg_sel`=3 returns 8'h00 in every mode.
- R10: `fd_pin_oe` equals `fdc_oe` except when a routed drive is selected, and then it is all zero. A routed drive is selected when `drv_sel_en`=1 and either the mode is 01 with `drv_sel_num`=1, or the mode is 10 with either drive number.
- R11: `fd_pin_out` always equals `fdc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_wdata | input | 2 | Mode value to store |
| cfg_mode | output | 2 | Stored raw mode value |
| reg_sel | input | 2 | Host register select: 0 data, 1 status, 2 control, 3 none |
| reg_wr | input | 1 | Host register write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data |
| eng_reg_wr | output | 1 | Write strobe forwarded to the parallel engine |
| eng_data_rd | input | 8 | Engine data register readback |
| eng_status_rd | input | 8 | Engine status register readback |
| eng_ctrl_rd | input | 8 | Engine control register readback |
| eng_enable | input | 1 | Engine enable / powered indication |
| eng_pin_out | input | PIN_W (17) | Engine pin output values |
| eng_pin_oe | input | PIN_W (17) | Engine pin output enables |
| fdc_pin_out | input | PIN_W (17) | Floppy signals arranged in parallel-pin order |
| fdc_pin_oe | input | PIN_W (17) | Enables for those floppy signals |
| fdc_out | input | FD_W (10) | Floppy controller dedicated output values |
| fdc_oe | input | FD_W (10) | Floppy controller dedicated output enables |
| drv_sel_en | input | 1 | A drive is currently selected |
| drv_sel_num | input | 1 | Number of the selected drive |
| pp_pin_out | output | PIN_W (17) | Parallel pin output values |
| pp_pin_oe | output | PIN_W (17) | Parallel pin tristate enables |
| fd_pin_out | output | FD_W (10) | Dedicated floppy pin values |
| fd_pin_oe | output | FD_W (10) | Dedicated floppy pin tristate enables |

## Verification
Only two pieces of state exist, the stored mode and the echo byte, and an error in either shows at the ports in the first cycle after the write that set it. A corrupted mode changes the parallel pin source, the host readback and the dedicated enables all at once. A wrong echo byte shows only on a floppy-mode data read, so the sweep writes distinct bytes in every mode and reads them back after switching into a floppy mode. The drive-select gating is purely combinational. The sweep walks every combination of mode, select-enable, drive number and engine enable, and checks each output immediately.

// File: rtl/ppfd_pkg.sv
package ppfd_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_FD1    = 2'b01,
    MODE_FD2    = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SEL_DATA   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } regsel_e;

  // "no cable" readback constants
  localparam logic [7:0] NOCAB_STATUS = 8'h48;
  localparam logic [7:0] NOCAB_CTRL   = 8'h04;
endpackage

// File: rtl/ppfd_rst_sync.sv
module ppfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ppfd_mode_reg.sv
module ppfd_mode_reg
  import ppfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_wdata,
  output logic [1:0] mode_raw,
  output logic       fd_active,
  output logic       route_d0,
  output logic       route_d1
);
  logic [1:0] mode_q;
  logic [1:0] mode_d;
  logic       mode_en;

  always_comb begin
    mode_en = cfg_wr;
    mode_d  = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_NORMAL;
    else if (mode_en) mode_q <= mode_d;
  end

  always_comb begin
    fd_active = 1'b0;
    route_d0  = 1'b0;
    route_d1  = 1'b0;
    unique case (mode_q)
      MODE_FD1: begin
        fd_active = 1'b1;
        route_d1  = 1'b1;
      end
      MODE_FD2: begin
        fd_active = 1'b1;
        route_d0  = 1'b1;
        route_d1  = 1'b1;
      end
      default: ;
    endcase
  end

  assign mode_raw = mode_q;
endmodule

// File: rtl/ppfd_data_latch.sv
module ppfd_data_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q
);
  logic [DATA_W-1:0] data_d;
  logic              data_en;

  always_comb begin
    data_en = wr_en;
    data_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end
endmodule

// File: rtl/ppfd_readback.sv
module ppfd_readback
  import ppfd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              fd_active,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] echo_data,
  input  logic [DATA_W-1:0] eng_data_rd,
  input  logic [DATA_W-1:0] eng_status_rd,
  input  logic [DATA_W-1:0] eng_ctrl_rd,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    unique case (reg_sel)
      SEL_DATA:   rdata = fd_active ? echo_data : eng_data_rd;
      SEL_STATUS: rdata = fd_active ? DATA_W'(NOCAB_STATUS) : eng_status_rd;
      SEL_CTRL:   rdata = fd_active ? DATA_W'(NOCAB_CTRL) : eng_ctrl_rd;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/ppfd_pin_mux.sv
module ppfd_pin_mux #(
  parameter int PIN_W = 17,
  parameter int FD_W  = 10
) (
  input  logic             fd_active,
  input  logic             eng_enable,
  input  logic             float_ded,
  input  logic [PIN_W-1:0] eng_pin_out,
  input  logic [PIN_W-1:0] eng_pin_oe,
  input  logic [PIN_W-1:0] fdc_pin_out,
  input  logic [PIN_W-1:0] fdc_pin_oe,
  input  logic [FD_W-1:0]  fdc_oe,
  output logic [PIN_W-1:0] pp_pin_out,
  output logic [PIN_W-1:0] pp_pin_oe,
  output logic [FD_W-1:0]  fd_pin_oe
);
  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    always_comb begin
      if (fd_active) begin
        pp_pin_out[p] = fdc_pin_out[p];
        pp_pin_oe[p]  = fdc_pin_oe[p];
      end else begin
        pp_pin_out[p] = eng_pin_out[p];
        pp_pin_oe[p]  = eng_pin_oe[p] & eng_enable;
      end
    end
  end

  for (genvar f = 0; f < FD_W; f++) begin : g_ded
    assign fd_pin_oe[f] = fdc_oe[f] & ~float_ded;
  end
endmodule

// File: rtl/ppfd_pinshare.sv
module ppfd_pinshare
  import ppfd_pkg::*;
#(
  parameter int PIN_W  = 17,
  parameter int FD_W   = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_wdata,
  output logic [1:0]        cfg_mode,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              eng_reg_wr,
  input  logic [DATA_W-1:0] eng_data_rd,
  input  logic [DATA_W-1:0] eng_status_rd,
  input  logic [DATA_W-1:0] eng_ctrl_rd,
  input  logic              eng_enable,
  input  logic [PIN_W-1:0]  eng_pin_out,
  input  logic [PIN_W-1:0]  eng_pin_oe,
  input  logic [PIN_W-1:0]  fdc_pin_out,
  input  logic [PIN_W-1:0]  fdc_pin_oe,
  input  logic [FD_W-1:0]   fdc_out,
  input  logic [FD_W-1:0]   fdc_oe,
  input  logic              drv_sel_en,
  input  logic              drv_sel_num,
  output logic [PIN_W-1:0]  pp_pin_out,
  output logic [PIN_W-1:0]  pp_pin_oe,
  output logic [FD_W-1:0]   fd_pin_out,
  output logic [FD_W-1:0]   fd_pin_oe
);
  logic              rst_sync_n;
  logic              fd_active;
  logic              route_d0;
  logic              route_d1;
  logic              float_ded;
  logic              data_wr;
  logic [DATA_W-1:0] echo_q;

  ppfd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ppfd_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .mode_raw  (cfg_mode),
    .fd_active (fd_active),
    .route_d0  (route_d0),
    .route_d1  (route_d1)
  );

  assign data_wr = reg_wr & (reg_sel == SEL_DATA);

  ppfd_data_latch #(.DATA_W(DATA_W)) u_echo (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (data_wr),
    .wdata  (reg_wdata),
    .data_q (echo_q)
  );

  ppfd_readback #(.DATA_W(DATA_W)) u_rb (
    .fd_active     (fd_active),
    .reg_sel       (reg_sel),
    .echo_data     (echo_q),
    .eng_data_rd   (eng_data_rd),
    .eng_status_rd (eng_status_rd),
    .eng_ctrl_rd   (eng_ctrl_rd),
    .rdata         (reg_rdata)
  );

  // a routed drive being selected floats the dedicated pins
  always_comb begin
    float_ded = fd_active & drv_sel_en & (drv_sel_num ? route_d1 : route_d0);
  end

  ppfd_pin_mux #(.PIN_W(PIN_W), .FD_W(FD_W)) u_mux (
    .fd_active   (fd_active),
    .eng_enable  (eng_enable),
    .float_ded   (float_ded),
    .eng_pin_out (eng_pin_out),
    .eng_pin_oe  (eng_pin_oe),
    .fdc_pin_out (fdc_pin_out),
    .fdc_pin_oe  (fdc_pin_oe),
    .fdc_oe      (fdc_oe),
    .pp_pin_out  (pp_pin_out),
    .pp_pin_oe   (pp_pin_oe),
    .fd_pin_oe   (fd_pin_oe)
  );

  assign fd_pin_out = fdc_out;
  assign eng_reg_wr = reg_wr & ~fd_active;
endmodule

// File: rtl/ppfd_pinshare_chk.sv
module ppfd_pinshare_chk #(
  parameter int PIN_W  = 17,
  parameter int FD_W   = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              cfg_wr,
  input logic [1:0]        cfg_wdata,
  input logic [1:0]        cfg_mode,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              eng_reg_wr,
  input logic [PIN_W-1:0]  eng_pin_out,
  input logic [PIN_W-1:0]  fdc_pin_out,
  input logic [PIN_W-1:0]  fdc_pin_oe,
  input logic [PIN_W-1:0]  pp_pin_out,
  input logic [PIN_W-1:0]  pp_pin_oe,
  input logic [FD_W-1:0]   fdc_out,
  input logic [FD_W-1:0]   fdc_oe,
  input logic [FD_W-1:0]   fd_pin_out,
  input logic [FD_W-1:0]   fd_pin_oe,
  input logic              drv_sel_en
);
  logic fd;
  assign fd = (cfg_mode == 2'b01) || (cfg_mode == 2'b10);

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_wr |=> cfg_mode == $past(cfg_wdata)); // R2
  AST_NORMAL_PINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fd |-> pp_pin_out == eng_pin_out); // R3
  AST_FD_PINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fd |-> (pp_pin_out == fdc_pin_out) && (pp_pin_oe == fdc_pin_oe)); // R4
  AST_ENG_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fd |-> !eng_reg_wr); // R5
  AST_DATA_ECHO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fd && reg_sel == 2'd0 && $past(rst_sync_n) && $past(reg_wr && reg_sel == 2'd0))
      |-> reg_rdata == $past(reg_wdata)); // R6
  AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fd && reg_sel == 2'd1) |-> reg_rdata == DATA_W'(8'h48)); // R7
  AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fd && reg_sel == 2'd2) |-> reg_rdata == DATA_W'(8'h04)); // R8
  AST_NOSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_sel == 2'd3) |-> reg_rdata == '0); // R9
  AST_MODE2_FLOAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_mode == 2'b10 && drv_sel_en) |-> fd_pin_oe == '0); // R10
  AST_NORMAL_DED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fd |-> fd_pin_oe == fdc_oe); // R10
  AST_DED_OUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fd_pin_out == fdc_out); // R11
endmodule

bind ppfd_pinshare ppfd_pinshare_chk #(.PIN_W(PIN_W), .FD_W(FD_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .cfg_wr      (cfg_wr),
  .cfg_wdata   (cfg_wdata),
  .cfg_mode    (cfg_mode),
  .reg_sel     (reg_sel),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .eng_reg_wr  (eng_reg_wr),
  .eng_pin_out (eng_pin_out),
  .fdc_pin_out (fdc_pin_out),
  .fdc_pin_oe  (fdc_pin_oe),
  .pp_pin_out  (pp_pin_out),
  .pp_pin_oe   (pp_pin_oe),
  .fdc_out     (fdc_out),
  .fdc_oe      (fdc_oe),
  .fd_pin_out  (fd_pin_out),
  .fd_pin_oe   (fd_pin_oe),
  .drv_sel_en  (drv_sel_en)
);

// File: tb/ppfd_pinshare_tb.sv
module ppfd_pinshare_tb;
  localparam int CLK_P = 10;
  localparam int PIN_W = 17;
  localparam int FD_W  = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_wr;
  logic [1:0]       cfg_wdata;
  logic [1:0]       cfg_mode;
  logic [1:0]       reg_sel;
  logic             reg_wr;
  logic [7:0]       reg_wdata;
  logic [7:0]       reg_rdata;
  logic             eng_reg_wr;
  logic [7:0]       eng_data_rd, eng_status_rd, eng_ctrl_rd;
  logic             eng_enable;
  logic [PIN_W-1:0] eng_pin_out, eng_pin_oe, fdc_pin_out, fdc_pin_oe;
  logic [FD_W-1:0]  fdc_out, fdc_oe;
  logic             drv_sel_en, drv_sel_num;
  logic [PIN_W-1:0] pp_pin_out, pp_pin_oe;
  logic [FD_W-1:0]  fd_pin_out, fd_pin_oe;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  ppfd_pinshare #(.PIN_W(PIN_W), .FD_W(FD_W), .DATA_W(8)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = m;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    #1;
    chk((cfg_mode == 2'b01 || cfg_mode == 2'b10) ? "R5" : "R3", 32'(eng_reg_wr),
        32'(!(cfg_mode == 2'b01 || cfg_mode == 2'b10)));
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] last_wr;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; reg_sel = '0; reg_wr = 1'b0;
    reg_wdata = '0; eng_data_rd = 8'h3C; eng_status_rd = 8'hB7; eng_ctrl_rd = 8'hE1;
    eng_enable = 1'b1; eng_pin_out = '0; eng_pin_oe = '0; fdc_pin_out = '0;
    fdc_pin_oe = '0; fdc_out = '0; fdc_oe = '0; drv_sel_en = 1'b0; drv_sel_num = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", 32'(cfg_mode), 32'h0);
    set_mode(2'b01);
    reg_sel = 2'd0; #1;
    chk("R1", 32'(reg_rdata), 32'h00);
    set_mode(2'b00);
    #1;
    chk("R2", 32'(cfg_mode), 32'h0);

    // R6: echo across every write mode and read mode
    last_wr = 8'h00;
    for (int wm = 0; wm < 4; wm++) begin
      for (int rm = 1; rm < 3; rm++) begin
        logic [7:0] v;
        v = 8'(8'h11 * (wm * 3 + rm) + 8'h05);
        set_mode(2'(wm));
        host_write(2'd0, v);
        host_write(2'd1, ~v); // non-data write must not disturb the echo
        set_mode(2'(rm));
        reg_sel = 2'd0; #1;
        chk("R6", 32'(reg_rdata), 32'(v));
        last_wr = v;
      end
    end

    // sweep of modes, drive select, engine enable and pin patterns
    for (int m = 0; m < 4; m++) begin
      set_mode(2'(m));
      #1;
      chk("R2", 32'(cfg_mode), 32'(m));
      for (int k = 0; k < 3; k++) begin
        for (int en = 0; en < 2; en++) begin
          for (int num = 0; num < 2; num++) begin
            for (int ee = 0; ee < 2; ee++) begin
              logic fd, flt;
              @(negedge clk);
              eng_pin_out = PIN_W'(32'h15555 ^ (k * 32'h0321));
              eng_pin_oe  = PIN_W'(32'h0F0F3 + k * 32'h1111);
              fdc_pin_out = PIN_W'(32'h0AAAA ^ (k * 32'h2C07));
              fdc_pin_oe  = PIN_W'(32'h1E1E1 - k * 32'h0B35);
              fdc_out     = FD_W'(32'h2A5 + k * 32'h91);
              fdc_oe      = FD_W'(32'h3F0 ^ (k * 32'h0E3));
              eng_data_rd = 8'(8'h3C + k); eng_status_rd = 8'(8'hB7 ^ k);
              eng_ctrl_rd = 8'(8'hE1 - k);
              drv_sel_en = en[0]; drv_sel_num = num[0]; eng_enable = ee[0];
              fd  = (m == 1) || (m == 2);
              flt = fd && en == 1 && (num == 1 || m == 2);
              #1;
              if (fd) begin
                chk("R4", 32'(pp_pin_out), 32'(fdc_pin_out));
                chk("R4", 32'(pp_pin_oe), 32'(fdc_pin_oe));
              end else begin
                chk("R3", 32'(pp_pin_out), 32'(eng_pin_out));
                chk("R3", 32'(pp_pin_oe), 32'(ee == 1 ? eng_pin_oe : '0));
              end
              chk("R10", 32'(fd_pin_oe), 32'(flt ? '0 : fdc_oe));
              chk("R11", 32'(fd_pin_out), 32'(fdc_out));
              for (int s = 0; s < 4; s++) begin
                logic [7:0] e;
                reg_sel = 2'(s); #1;
                case (s)
                  0: e = fd ? last_wr : eng_data_rd;
                  1: e = fd ? 8'h48 : eng_status_rd;
                  2: e = fd ? 8'h04 : eng_ctrl_rd;
                  default: e = 8'h00;
                endcase
                chk(s == 0 ? (fd ? "R6" : "R3") : s == 1 ? (fd ? "R7" : "R3") :
                    s == 2 ? (fd ? "R8" : "R3") : "R9", 32'(reg_rdata), 32'(e));
              end
            end
          end
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule